// File: doc/BRIEF.md
# Write-Status Read Multiplexer

This block forms the read data path of a byte-wide nonvolatile memory model. On each clock it chooses what a host read returns. In normal operation the value is the array byte that the storage logic presents. While identification mode is active, a small decoder returns the manufacturer code or the device code. While an internal write or erase is running, the block returns a status byte that lets the host poll for completion, in place of stored data.

Two status mechanisms are provided during a write. Bit 7 is the complement of bit 7 of the last byte loaded. Bit 6 alternates from one read to the next. During an erase only the alternating bit carries information. A read counts once, on the rising edge of the read strobe, so a strobe held high across many clocks is a single read. The first read after a write or erase begins always shows bit 6 = 1.

The result is registered. The output enable models the tristate control of the pins: data is valid only when both chip enable and output enable were asserted, and the data lines are driven to zero otherwise. Array storage and command decoding are handled by other blocks.

Top module: `wsr_read_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_oe` is 0 and `rd_data` is 00h.
- R2: `rd_oe` is 1 one cycle after `chip_en` and `out_en` are both 1, and 0 otherwise. When `rd_oe` is 0, `rd_data` is 00h.
- R3: With `busy` = 0 and `id_mode` = 0, `rd_data` equals the `array_data` presented in the previous cycle.
- R4: With `busy` = 1 and `erasing` = 0, `rd_data` bit 7 is the inverse of `last_byte` bit 7 and bits 5..0 equal `last_byte` bits 5..0.
- R5: With `busy` = 1, each rising edge of `rd_stb` is one read. Bit 6 of successive reads alternates 1, 0, 1 and so on, and the first read after `busy` rises returns 1.
- R6: While `rd_stb` stays high, or stays low between reads, bit 6 keeps the value of the last read and does not advance.
- R7: With `busy` = 1 and `erasing` = 1, bit 6 alternates as in R5, and bits 7 and 5..0 are 0.
- R8: When `busy` falls, the following reads return the true array data. When the next operation starts, the alternation restarts so that its first read returns bit 6 = 1.
- R9: With `busy` = 0, `id_mode` = 1 and address bits 14..1 all zero, a read with address bit 0 = 0 returns BFh. A read with address bit 0 = 1 returns the device code: 12h when `DEV_SEL` = 1 (default) and 10h when `DEV_SEL` = 0. Address bits above 14 are ignored.
- R10: In identification mode, any nonzero address bit in 14..1 makes the read return FFh.
- R11: `busy` takes priority over `id_mode`, so a busy read returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| addr | input | ADDR_W (18) | Read address |
| busy | input | 1 | Internal write or erase in progress |
| erasing | input | 1 | The busy operation is an erase |
| id_mode | input | 1 | Identification mode active |
| last_byte | input | DATA_W (8) | Last byte loaded by the host |
| array_data | input | DATA_W (8) | Byte read from the array |
| rd_data | output | DATA_W (8) | Registered read value |
| rd_oe | output | 1 | Drive enable for the data pins |

## Verification
Every result is registered once, so the value for inputs present at a rising edge appears right after that edge and holds until the next one. The bench changes inputs on the falling edge, lets one rising edge pass, and compares on the following falling edge, exactly one cycle later. This applies to status bits as well. The alternating bit depends on the strobe edge history, so the vector table is ordered to carry the expected state of the alternation from row to row, with held-strobe rows placed between edge rows.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   localparam logic [7:0] MFR_CODE     = 8'hBF;
   localparam logic [7:0] DEV_CODE_LO  = 8'h10;
   localparam logic [7:0] DEV_CODE_HI  = 8'h12;
   localparam logic [7:0] ID_MISS_FILL = 8'hFF;

   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;
   localparam int ID_TOP   = 14;

   typedef enum logic [1:0] {
      SRC_OFF    = 2'd0,
      SRC_ARRAY  = 2'd1,
      SRC_ID     = 2'd2,
      SRC_STATUS = 2'd3
   } rd_src_e;

endpackage

// File: rtl/wsr_rise_det.sv
module wsr_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_in;
   end

   assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/wsr_toggle_trk.sv
module wsr_toggle_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_rise,
   output logic tog_now
);
   // next_q: value the next read will see; shown_q: value of the last read
   logic next_q;
   logic shown_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q  <= 1'b1;
         shown_q <= 1'b1;
      end else if (!busy) begin
         next_q  <= 1'b1;
         shown_q <= 1'b1;
      end else if (rd_rise) begin
         next_q  <= ~next_q;
         shown_q <= next_q;
      end
   end

   assign tog_now = rd_rise ? next_q : shown_q;
endmodule

// File: rtl/wsr_id_decode.sv
module wsr_id_decode #(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 8,
   parameter int DEV_SEL = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] id_byte
);
   import wsr_pkg::*;

   localparam int ZERO_W = ID_TOP;

   logic [DATA_W-1:0] dev_code;
   logic              upper_clear;

   generate
      if (DEV_SEL == 0) begin : g_dev_lo
         assign dev_code = DATA_W'(DEV_CODE_LO);
      end else begin : g_dev_hi
         assign dev_code = DATA_W'(DEV_CODE_HI);
      end
   endgenerate

   assign upper_clear = (addr[ID_TOP:1] == ZERO_W'(0));

   always_comb begin
      if (!upper_clear)  id_byte = DATA_W'(ID_MISS_FILL);
      else if (addr[0])  id_byte = dev_code;
      else               id_byte = DATA_W'(MFR_CODE);
   end
endmodule

// File: rtl/wsr_status_fmt.sv
module wsr_status_fmt #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] last_byte,
   input  logic              erasing,
   input  logic              tog_now,
   output logic [DATA_W-1:0] status
);
   import wsr_pkg::*;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_bit
         if (gi == TOG_BIT) begin : g_tog
            assign status[gi] = tog_now;
         end else if (gi == POLL_BIT) begin : g_poll
            assign status[gi] = ~erasing & ~last_byte[gi];
         end else begin : g_pass
            assign status[gi] = ~erasing & last_byte[gi];
         end
      end
   endgenerate
endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux #(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 8,
   parameter int DEV_SEL = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              out_en,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   input  logic              erasing,
   input  logic              id_mode,
   input  logic [DATA_W-1:0] last_byte,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   import wsr_pkg::*;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("wsr_read_mux: DATA_W must be 8 for the status bit layout");
      end
      if (ADDR_W <= ID_TOP) begin : g_bad_addr_w
         $error("wsr_read_mux: ADDR_W must exceed the identification address field");
      end
      if (DEV_SEL != 0 && DEV_SEL != 1) begin : g_bad_dev_sel
         $error("wsr_read_mux: DEV_SEL must be 0 or 1");
      end
   endgenerate

   logic              rd_rise;
   logic              tog_now;
   logic [DATA_W-1:0] id_byte;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] sel_byte;
   rd_src_e           src;

   wsr_rise_det u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (rd_stb),
      .rise   (rd_rise)
   );

   wsr_toggle_trk u_tog (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .rd_rise (rd_rise),
      .tog_now (tog_now)
   );

   wsr_id_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .DEV_SEL (DEV_SEL)
   ) u_id (
      .addr    (addr),
      .id_byte (id_byte)
   );

   wsr_status_fmt #(
      .DATA_W (DATA_W)
   ) u_stat (
      .last_byte (last_byte),
      .erasing   (erasing),
      .tog_now   (tog_now),
      .status    (status)
   );

   always_comb begin
      if (!(chip_en && out_en)) src = SRC_OFF;
      else if (busy)            src = SRC_STATUS;
      else if (id_mode)         src = SRC_ID;
      else                      src = SRC_ARRAY;
   end

   always_comb begin
      unique case (src)
         SRC_STATUS: sel_byte = status;
         SRC_ID:     sel_byte = id_byte;
         SRC_ARRAY:  sel_byte = array_data;
         default:    sel_byte = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_oe   <= 1'b0;
      end else begin
         rd_data <= sel_byte;
         rd_oe   <= (src != SRC_OFF);
      end
   end
endmodule

// File: rtl/wsr_read_mux_chk.sv
module wsr_read_mux_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              out_en,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] addr,
   input logic              busy,
   input logic              erasing,
   input logic              id_mode,
   input logic [DATA_W-1:0] last_byte,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_oe
);
   logic en;
   assign en = chip_en & out_en;

   p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> rd_oe);

   p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rd_oe && rd_data == '0));

   p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !busy && !id_mode) |=> rd_data == $past(array_data));

   p_poll_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && !erasing) |=> (rd_data[7] == ~$past(last_byte[7])));

   p_first_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && !$past(busy) && rd_stb && !$past(rd_stb)) |=> rd_data[6]);

   p_held_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && busy && $past(busy) && rd_stb && $past(rd_stb))
      |=> rd_data[6] == $past(rd_data[6]));

   p_erase_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && erasing) |=> (rd_data[7] == 1'b0 && rd_data[5:0] == 6'd0));

   p_id_mfr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !busy && id_mode && addr[14:0] == 15'd0) |=> rd_data == 8'hBF);
endmodule

bind wsr_read_mux wsr_read_mux_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_en    (chip_en),
   .out_en     (out_en),
   .rd_stb     (rd_stb),
   .addr       (addr),
   .busy       (busy),
   .erasing    (erasing),
   .id_mode    (id_mode),
   .last_byte  (last_byte),
   .array_data (array_data),
   .rd_data    (rd_data),
   .rd_oe      (rd_oe)
);

// File: tb/tb_wsr_read_mux.sv
module tb_wsr_read_mux;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 18;
   localparam int NVEC   = 22;

   typedef struct packed {
      logic        ce;
      logic        oe;
      logic        stb;
      logic        bsy;
      logic        ers;
      logic        idm;
      logic [17:0] adr;
      logic [7:0]  lst;
      logic [7:0]  arr;
      logic        e_oe;
      logic [7:0]  e_dat;
      logic [7:0]  req;
   } vec_t;

   // ce oe stb bsy ers idm addr last arr | exp_oe exp_data req
   localparam vec_t VECS [NVEC] = '{
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,18'h00000,8'h00,8'h5A, 1'b0,8'h00, 8'd2},  // R2 idle off
      '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,18'h00123,8'h00,8'h5A, 1'b1,8'h5A, 8'd3},  // R3 array
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,18'h00124,8'h00,8'hC3, 1'b1,8'hC3, 8'd3},  // R3 array
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,18'h00124,8'h00,8'hC3, 1'b0,8'h00, 8'd2},  // R2 oe low
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h56, 8'd5},  // R4 R5 first read
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h56, 8'd6},  // R6 held high
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h56, 8'd6},  // R6 low gap
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h16, 8'd5},  // R5 second read
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h16, 8'd6},  // R6 low gap
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,18'h00010,8'h96,8'h11, 1'b1,8'h56, 8'd5},  // R5 third read
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,18'h00010,8'h96,8'h96, 1'b1,8'h96, 8'd8},  // R8 true data
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,18'h00010,8'h96,8'h96, 1'b1,8'h40, 8'd7},  // R7 erase first
      '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,18'h00010,8'h96,8'h96, 1'b1,8'h40, 8'd7},  // R7 gap
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,18'h00010,8'h96,8'h96, 1'b1,8'h00, 8'd7},  // R7 second
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,18'h00000,8'h01,8'h96, 1'b1,8'h81, 8'd11}, // R11 busy over id
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,18'h00000,8'h01,8'h96, 1'b1,8'hBF, 8'd9},  // R9 maker
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,18'h00001,8'h01,8'h96, 1'b1,8'h12, 8'd9},  // R9 device
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,18'h38001,8'h01,8'h96, 1'b1,8'h12, 8'd9},  // R9 high bits ignored
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,18'h00002,8'h01,8'h96, 1'b1,8'hFF, 8'd10}, // R10 bit1 set
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,18'h04000,8'h01,8'h96, 1'b1,8'hFF, 8'd10}, // R10 bit14 set
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,18'h00000,8'h01,8'h3C, 1'b1,8'h3C, 8'd3},  // R3 back to array
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,18'h00000,8'h01,8'h3C, 1'b0,8'h00, 8'd2}   // R2 ce low
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chip_en = 1'b0, out_en = 1'b0, rd_stb = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              busy = 1'b0, erasing = 1'b0, id_mode = 1'b0;
   logic [7:0]        last_byte = '0, array_data = '0;
   logic [7:0]        rd_data;
   logic              rd_oe;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   wsr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(8), .DEV_SEL(1)) dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
      .rd_stb(rd_stb), .addr(addr), .busy(busy), .erasing(erasing),
      .id_mode(id_mode), .last_byte(last_byte), .array_data(array_data),
      .rd_data(rd_data), .rd_oe(rd_oe)
   );

   task automatic check(input string req, input logic a_oe, input logic [7:0] a_d,
                        input logic e_oe, input logic [7:0] e_d);
      n_chk++;
      if (a_oe !== e_oe || a_d !== e_d) begin
         n_fail++;
         $display("FAIL %s: oe=%0b data=%02h, expected oe=%0b data=%02h",
                  req, a_oe, a_d, e_oe, e_d);
      end
   endtask

   task automatic drive(input vec_t v);
      chip_en = v.ce; out_en = v.oe; rd_stb = v.stb; busy = v.bsy;
      erasing = v.ers; id_mode = v.idm; addr = v.adr;
      last_byte = v.lst; array_data = v.arr;
   endtask

   // apply at falling edge, one rising edge, sample at next falling edge
   task automatic step_check(input vec_t v, input string req);
      drive(v);
      @(posedge clk);
      @(negedge clk);
      check(req, rd_oe, rd_data, v.e_oe, v.e_dat);
   endtask

   function automatic vec_t mk(input logic stb, input logic bsy, input logic ers,
                               input logic [7:0] lst, input logic [7:0] ed);
      vec_t v;
      v = '{1'b1,1'b1,stb,bsy,ers,1'b0,18'h0,lst,8'hA5,1'b1,ed,8'd0};
      return v;
   endfunction

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state, with enables active during reset
      chip_en = 1'b1; out_en = 1'b1; array_data = 8'h77;
      repeat (3) @(negedge clk);
      check("R1 in reset", rd_oe, rd_data, 1'b0, 8'h00);
      chip_en = 1'b0; out_en = 1'b0;
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1 after reset", rd_oe, rd_data, 1'b0, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         step_check(VECS[i], $sformatf("R%0d vec%0d", VECS[i].req, i));
      end

      // R8: rearm after two reads leave the alternation at 0
      step_check(mk(1'b1,1'b1,1'b0,8'h00,8'hC0), "R8 op1 read1");
      step_check(mk(1'b0,1'b1,1'b0,8'h00,8'hC0), "R8 op1 gap");
      step_check(mk(1'b1,1'b1,1'b0,8'h00,8'h80), "R8 op1 read2");
      step_check(mk(1'b0,1'b0,1'b0,8'h00,8'hA5), "R8 idle array");
      step_check(mk(1'b1,1'b1,1'b0,8'h00,8'hC0), "R8 op2 first read");

      // R4: bit7 of last byte clear gives polled bit7 = 1
      step_check(mk(1'b0,1'b1,1'b0,8'h2A,8'hEA), "R4 bit7 clear");

      // R1: mid-run reset clears output and rearms alternation
      step_check(mk(1'b1,1'b1,1'b0,8'h00,8'h80), "R5 before reset");
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset", rd_oe, rd_data, 1'b0, 8'h00);
      drive(mk(1'b0,1'b1,1'b0,8'h00,8'h00));
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      step_check(mk(1'b1,1'b1,1'b0,8'h00,8'hC0), "R5 first read after reset");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule